// File: doc/BRIEF.md
# Receive Byte Queue with Overrun Protection

This block is the character queue that sits between a serial deserializer and the receive-buffer read port of a 16550-style UART. Each character the deserializer completes is pushed into a sixteen-entry, eight-bit circular store. Each read of the receive buffer pops the oldest entry. The block keeps an occupancy count and compares it with a programmable threshold to produce a receive-data request.

When the store is already full, an arriving character is dropped. The entries already held stay untouched, and a sticky overrun flag is raised. A detected line break is queued as a zero byte and raises a sticky break flag. A status acknowledge, given when software reads the line status, clears both sticky flags. A clear input empties the queue in a single cycle.

Top module: `rx_byte_queue`

## Requirements
- R1: A push (data or break) while the count is 16 writes no entry and leaves the write position unchanged, so the 16 stored bytes later pop out in their original order.
- R2: A push (data or break) while the count is 16 sets `overrun_flag` on the next edge, and the count stays at 16 unless a pop occurs in the same cycle.
- R3: A push while the count is below 16 stores the byte and raises the count by one. The write and read positions wrap from 15 back to 0, so order is kept across any number of fill and drain rounds.
- R4: With `fifo_en` = 1, `rx_req` is 1 exactly when the count is at least the level chosen by `trig_sel`: 2'b00 selects 1, 2'b01 selects 4, 2'b10 selects 8 and 2'b11 selects 14. `trig_sel` acts combinationally.
- R5: With `fifo_en` = 0, `rx_req` equals `data_ready`, whatever `trig_sel` holds.
- R6: `brk_det` pushes a 0x00 byte and takes precedence over `push_valid` in the same cycle, so only one entry is added. It also sets `break_flag` on the next edge.
- R7: A pop with a nonzero count loads the oldest byte into `pop_data` on the same clock edge, advances the read position and lowers the count by one. `pop_data` holds its value until the next pop.
- R8: A pop with a count of 0 loads 0x00 into `pop_data` and leaves the count and the stored contents unchanged.
- R9: `data_ready` is 1 exactly when the count is nonzero.
- R10: `clear` empties the queue on the next edge. During a clear cycle, push, break and pop have no effect. `clear` does not change either sticky flag.
- R11: `status_ack` clears `overrun_flag` and `break_flag` on the next edge. A new overrun or break event in the same cycle keeps its flag set.
- R12: A push and a pop in the same cycle on a partly filled queue leave the count unchanged.
- R13: After synchronous reset, the count is 0, both flags are 0 and `pop_data` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Deserializer has a character to store |
| push_data | input | 8 | Character to store |
| brk_det | input | 1 | Line break detected; queues a zero byte |
| pop_req | input | 1 | Receive-buffer read; removes the oldest entry |
| pop_data | output | 8 | Registered byte from the most recent pop |
| clear | input | 1 | Empties the queue |
| fifo_en | input | 1 | 1 selects threshold mode for `rx_req` |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14) |
| status_ack | input | 1 | Line-status read; clears the sticky flags |
| count | output | 5 | Occupancy, 0 to 16 |
| data_ready | output | 1 | Queue is not empty |
| rx_req | output | 1 | Receive-data request |
| overrun_flag | output | 1 | Sticky: a character arrived while full |
| break_flag | output | 1 | Sticky: a break was queued |

## Verification
The hardest state to reach from the ports is a full queue that then receives further pushes, particularly when those pushes coincide with a pop, a break or a status acknowledge. The stimulus mixes directed overflow sequences with random phases. Some random phases weight pushes heavily, which drives the queue to 16 and past it many times, with random pops, breaks and acknowledges landing on the full boundary. A drain phase follows each overflow. It shows that the dropped characters left the stored order intact, including after the positions have wrapped.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Threshold for a two-bit select, scaled to the queue depth.
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic             rzero,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Write port with no reset, so the array can map to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with a synchronous reset on the output register.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rzero ? '0 : mem[raddr];
  end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             brk_det,
  input  logic             pop_req,
  input  logic             clear,
  input  logic             status_ack,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [WIDTH-1:0] wdata,
  output logic             re,
  output logic             rzero,
  output logic [AW-1:0]    raddr,
  output logic [CW-1:0]    cnt,
  output logic             ovr,
  output logic             brk
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;
  logic          ovr_q, brk_q;
  logic          push_any, pop_any, full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    push_any = (push_valid | brk_det) & ~clear;
    pop_any  = pop_req & ~clear;
    full     = (cnt_q == FULL_CNT);
    empty    = (cnt_q == '0);
    push_ok  = push_any & ~full;
    pop_ok   = pop_any & ~empty;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) head_q <= bump(head_q);
      if (pop_ok)  tail_q <= bump(tail_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
      brk_q <= 1'b0;
    end else begin
      ovr_q <= (push_any & full) | (ovr_q & ~status_ack);
      brk_q <= (brk_det & ~clear) | (brk_q & ~status_ack);
    end
  end

  assign we    = push_ok;
  assign waddr = head_q;
  assign wdata = brk_det ? '0 : push_data;
  assign re    = pop_any;
  assign rzero = empty;
  assign raddr = tail_q;
  assign cnt   = cnt_q;
  assign ovr   = ovr_q;
  assign brk   = brk_q;

  AST_FULL_HEAD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (full && push_any && !pop_any) |=> ($stable(head_q) && cnt_q == FULL_CNT)); // R1
  AST_FULL_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    (full && push_any) |=> ovr_q); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT); // R3
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_any && !push_any) |=> (cnt_q == '0 && $stable(tail_q))); // R8
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0)); // R10
  AST_BREAK_FLAG: assert property (@(posedge clk) disable iff (rst)
    (brk_det && !clear) |=> brk_q); // R6
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             brk_det,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  input  logic             clear,
  input  logic             fifo_en,
  input  logic [1:0]       trig_sel,
  input  logic             status_ack,
  output logic [CW-1:0]    count,
  output logic             data_ready,
  output logic             rx_req,
  output logic             overrun_flag,
  output logic             break_flag
);
  import rxq_pkg::*;

  logic             we, re, rzero;
  logic [AW-1:0]    waddr, raddr;
  logic [WIDTH-1:0] wdata;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    level;

  rxq_ctrl #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .brk_det(brk_det), .pop_req(pop_req), .clear(clear), .status_ack(status_ack),
    .we(we), .waddr(waddr), .wdata(wdata), .re(re), .rzero(rzero), .raddr(raddr),
    .cnt(cnt), .ovr(overrun_flag), .brk(break_flag)
  );

  rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .rzero(rzero), .raddr(raddr), .rdata(pop_data)
  );

  always_comb begin
    level      = CW'(trig_level(trig_sel, DEPTH));
    count      = cnt;
    data_ready = (cnt != '0);
    rx_req     = fifo_en ? (cnt >= level) : data_ready;
  end

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !clear && cnt == '0) |=> (pop_data == '0)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (status_ack && !push_valid && !brk_det) |=> (!overrun_flag && !break_flag)); // R11
  AST_BYPASS_MODE: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |-> (rx_req == (count != '0))); // R5
endmodule

// File: tb/sim_rx_byte_queue.sv
module sim_rx_byte_queue;
  logic       clk = 1'b0;
  logic       rst, push_valid, brk_det, pop_req, clear, fifo_en, status_ack;
  logic [7:0] push_data;
  logic [1:0] trig_sel;
  logic [7:0] pop_data;
  logic [4:0] count;
  logic       data_ready, rx_req, overrun_flag, break_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state.
  logic [7:0] m_mem [16];
  int         m_h, m_t, m_c;
  logic       m_ovr, m_brk;
  logic [7:0] m_pd;

  always #10 clk = ~clk;

  rx_byte_queue u0 (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .brk_det(brk_det), .pop_req(pop_req), .pop_data(pop_data), .clear(clear),
    .fifo_en(fifo_en), .trig_sel(trig_sel), .status_ack(status_ack),
    .count(count), .data_ready(data_ready), .rx_req(rx_req),
    .overrun_flag(overrun_flag), .break_flag(break_flag)
  );

  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string tag, input string ctx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  task automatic compare(input string ctx);
    int er;
    er = fifo_en ? int'(m_c >= lvl(trig_sel)) : int'(m_c != 0);
    chk("R3 count", ctx, int'(count), m_c);
    chk("R9 data_ready", ctx, int'(data_ready), int'(m_c != 0));
    chk(fifo_en ? "R4 rx_req" : "R5 rx_req", ctx, int'(rx_req), er);
    chk("R2 overrun_flag", ctx, int'(overrun_flag), int'(m_ovr));
    chk("R6 break_flag", ctx, int'(break_flag), int'(m_brk));
    chk("R7 pop_data", ctx, int'(pop_data), int'(m_pd));
  endtask

  // One clock cycle: drive, update the model at the edge, check at the falling edge.
  task automatic step(input bit p, input logic [7:0] d, input bit b, input bit r,
                      input bit c, input bit a, input string ctx);
    bit pa, full, ok;
    push_valid = p; push_data = d; brk_det = b; pop_req = r; clear = c; status_ack = a;
    @(posedge clk);
    pa   = (p | b) & ~c;
    full = (m_c == 16);
    ok   = 1'b0;
    if (!c && r) begin
      if (m_c == 0) m_pd = 8'h00;
      else begin
        m_pd = m_mem[m_t];
        m_t = (m_t + 1) % 16;
        m_c--;
      end
    end
    if (pa && !full) begin
      m_mem[m_h] = b ? 8'h00 : d;
      m_h = (m_h + 1) % 16;
      ok = 1'b1;
    end
    if (ok) m_c++;
    m_ovr = (pa && full) | (m_ovr & ~a);
    m_brk = (b & ~c) | (m_brk & ~a);
    if (c) begin m_h = 0; m_t = 0; m_c = 0; end
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1; push_valid = 0; push_data = 0; brk_det = 0; pop_req = 0;
    clear = 0; fifo_en = 1; trig_sel = 2'b00; status_ack = 0;
    m_h = 0; m_t = 0; m_c = 0; m_ovr = 0; m_brk = 0; m_pd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    compare("R13 reset state");

    // R1 R2: fill to 16, overflow three times, then drain in order.
    for (int i = 0; i < 16; i++) step(1, 8'(8'hA0 + i), 0, 0, 0, 0, "R3 fill");
    for (int i = 0; i < 3; i++) step(1, 8'h55, 0, 0, 0, 0, "R2 push while full");
    step(0, 0, 1, 0, 0, 0, "R1 break while full");
    step(0, 0, 0, 0, 0, 1, "R11 ack clears");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 0, "R1 drain keeps order");
    step(0, 0, 0, 1, 0, 0, "R8 pop empty");
    step(0, 0, 0, 1, 0, 0, "R8 pop empty again");

    // R4: threshold levels at each select value.
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int i = 0; i < 15; i++) step(1, 8'(i), 0, 0, 0, 0, "R4 threshold climb");
      step(0, 0, 0, 0, 1, 0, "R10 clear");
    end

    // R5: bypass mode ignores trig_sel.
    fifo_en = 0; trig_sel = 2'b11;
    step(1, 8'h11, 0, 0, 0, 0, "R5 bypass one byte");
    step(0, 0, 0, 1, 0, 0, "R5 bypass empty");
    fifo_en = 1;

    // R6: break wins over data in the same cycle.
    step(1, 8'hFF, 1, 0, 0, 0, "R6 break with data");
    step(0, 0, 0, 1, 0, 0, "R6 pop zero byte");

    // R11: overrun event together with ack keeps the flag.
    for (int i = 0; i < 16; i++) step(1, 8'(i), 0, 0, 0, 0, "R3 refill");
    step(1, 8'h77, 0, 0, 0, 1, "R11 set wins over ack");
    step(1, 8'h78, 0, 1, 0, 0, "R2 full push with pop");
    // R10: clear keeps flags and ignores push, pop and break.
    step(1, 8'h79, 1, 1, 1, 0, "R10 clear ignores others");
    // R12: simultaneous push and pop.
    step(1, 8'h01, 0, 0, 0, 0, "R12 setup");
    step(1, 8'h02, 0, 1, 0, 0, "R12 push and pop");

    // Random phases: push-heavy, balanced, drain-heavy.
    for (int ph = 0; ph < 12; ph++) begin
      int pp, pr;
      pp = (ph % 3 == 0) ? 90 : (ph % 3 == 1) ? 50 : 15;
      pr = (ph % 3 == 0) ? 20 : (ph % 3 == 1) ? 50 : 85;
      for (int i = 0; i < 250; i++) begin
        fifo_en  = ($urandom % 8) != 0;
        trig_sel = 2'($urandom % 4);
        step(($urandom % 100) < pp, 8'($urandom), ($urandom % 40) == 0,
             ($urandom % 100) < pr, ($urandom % 120) == 0, ($urandom % 10) == 0,
             "R12 random mix");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule